// File: doc/BRIEF.md
# Descriptor-Driven Byte Copy Engine

This block is a single-channel memory copy engine. Its work is set by a transfer descriptor held in a small register file: a current source address, a current destination address, a signed step for each of the two, a count of bytes to move per service request, a current and a starting iteration count, and a signed correction for each address that is applied once the whole job is done. A hardware requester raises `dma_req`. When requests are enabled and the engine is idle, the engine acknowledges with a one-cycle pulse and moves one burst of bytes (the minor loop) over a synchronous memory port with one cycle of read latency.

Every burst lowers the iteration count by one. The burst that takes the count from one to zero closes the job (the major loop). On that burst the engine adds the end corrections to both addresses, reloads the iteration count from its starting value and sets a done flag. If the interrupt enable is set, it also raises an interrupt flag. Software clears each flag with its own strobe bit. A typical use is a periodic copy of a fixed table. The end corrections are set to the negative of the bytes moved, so every job starts again from the same addresses.

Top module: `desc_copy_engine`

## Requirements
- R1: A started burst moves its bytes one at a time. Each byte is one read cycle (`mem_rd_en`=1, address = current source) and then one write cycle (`mem_wr_en`=1, address = current destination, data = the byte returned by that read). The burst moves exactly the programmed byte count.
- R2: After each byte is written, the source address adds its signed step and the destination address adds its own signed step, modulo 2^ADDR_W.
- R3: The iteration count drops by one per finished burst. A burst that finishes while the count is 0 or 1 ends the job, and the count reloads from the starting iteration count.
- R4: On the last byte of a job, each address receives its step and also its signed end correction. With a step of 1, a correction of -8 after 8 bytes returns both addresses to their start values.
- R5: `irq` rises at the end of a job only when interrupt-enable (control bit 1) is set. It stays high until bit 0 of the clear register is written as 1.
- R6: `done` rises at the end of every job, whatever the interrupt enable. It stays high until bit 1 of the clear register is written as 1.
- R7: `dma_req` is ignored when request-enable (control bit 0) is 0: no acknowledge and no memory access.
- R8: `dma_ack` pulses for one cycle, in the first read cycle of a burst. A burst only starts from idle, so a request held through a burst is not acknowledged again until the engine is idle.
- R9: A programmed byte count of 0 moves one byte.
- R10: Register indices on `cfg_idx`: 0 source address, 1 destination address, 2 source step, 3 destination step, 4 byte count, 5 current iteration count, 6 starting iteration count, 7 source end correction, 8 destination end correction, 9 control, 10 clear strobes. All flags and registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | CFG_W | Register write data |
| dma_req | input | 1 | Hardware service request |
| dma_ack | output | 1 | Burst start acknowledge pulse |
| irq | output | 1 | Job-complete interrupt flag |
| done | output | 1 | Job-complete flag |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | 8 | Memory write data |

## Verification
The hardest case to reach is the last byte of the last burst of a job. On that byte the step and the end correction land on the same address update, and the iteration count reloads in the same cycle. It can only be reached by driving several whole bursts through the request pin. The stimulus uses small byte counts and iteration counts of two, with unequal, negative and zero steps and corrections. It then runs further jobs to show that the reloaded count produces a second job of the same length. Held requests, disabled requests and a zero byte count are mixed in. A behavioural model predicts every memory access and flag in every cycle.

// File: rtl/dce_pkg.sv
package dce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } dce_state_t;

  localparam logic [3:0] IDX_SRC    = 4'd0;
  localparam logic [3:0] IDX_DST    = 4'd1;
  localparam logic [3:0] IDX_SSTEP  = 4'd2;
  localparam logic [3:0] IDX_DSTEP  = 4'd3;
  localparam logic [3:0] IDX_NBYTES = 4'd4;
  localparam logic [3:0] IDX_CITER  = 4'd5;
  localparam logic [3:0] IDX_BITER  = 4'd6;
  localparam logic [3:0] IDX_SCORR  = 4'd7;
  localparam logic [3:0] IDX_DCORR  = 4'd8;
  localparam logic [3:0] IDX_CTRL   = 4'd9;
  localparam logic [3:0] IDX_CLEAR  = 4'd10;

  localparam int CTRL_REQ_EN = 0;
  localparam int CTRL_IRQ_EN = 1;
  localparam int CLR_IRQ     = 0;
  localparam int CLR_DONE    = 1;
endpackage

// File: rtl/dce_addr_lane.sv
module dce_addr_lane #(
  parameter int         ADDR_W   = 16,
  parameter logic [3:0] IDX_ADDR = 4'd0,
  parameter logic [3:0] IDX_STEP = 4'd2,
  parameter logic [3:0] IDX_CORR = 4'd7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_val,
  input  logic              advance,
  input  logic              job_end,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, step_q, corr_q;
  logic [ADDR_W-1:0] extra;

  assign extra = job_end ? corr_q : '0;
  assign addr  = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      step_q <= '0;
      corr_q <= '0;
    end else begin
      if (cfg_we && cfg_idx == IDX_STEP) step_q <= cfg_val;
      if (cfg_we && cfg_idx == IDX_CORR) corr_q <= cfg_val;
      if (advance)
        addr_q <= addr_q + step_q + extra;
      else if (cfg_we && cfg_idx == IDX_ADDR)
        addr_q <= cfg_val;
    end
  end
endmodule

// File: rtl/dce_ctl_regs.sv
module dce_ctl_regs
  import dce_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_idx,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             burst_end,
  output logic [CNT_W-1:0] nbytes,
  output logic             iter_last,
  output logic             req_en,
  output logic             irq_en,
  output logic             clr_irq,
  output logic             clr_done
);
  logic [CNT_W-1:0] citer_q, biter_q, nbytes_q;
  logic             req_en_q, irq_en_q;

  assign nbytes    = nbytes_q;
  assign req_en    = req_en_q;
  assign irq_en    = irq_en_q;
  assign iter_last = (citer_q <= CNT_W'(1));
  assign clr_irq   = cfg_we && cfg_idx == IDX_CLEAR && cfg_wdata[CLR_IRQ];
  assign clr_done  = cfg_we && cfg_idx == IDX_CLEAR && cfg_wdata[CLR_DONE];

  always_ff @(posedge clk) begin
    if (rst) begin
      citer_q  <= '0;
      biter_q  <= '0;
      nbytes_q <= '0;
      req_en_q <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (cfg_we && cfg_idx == IDX_NBYTES) nbytes_q <= cfg_wdata[CNT_W-1:0];
      if (cfg_we && cfg_idx == IDX_BITER)  biter_q  <= cfg_wdata[CNT_W-1:0];
      if (cfg_we && cfg_idx == IDX_CTRL) begin
        req_en_q <= cfg_wdata[CTRL_REQ_EN];
        irq_en_q <= cfg_wdata[CTRL_IRQ_EN];
      end
      if (burst_end)
        citer_q <= iter_last ? biter_q : citer_q - CNT_W'(1);
      else if (cfg_we && cfg_idx == IDX_CITER)
        citer_q <= cfg_wdata[CNT_W-1:0];
    end
  end

  // R3: the burst that closes a job leaves the count at its starting value
  a_r3_count_reload: assert property (@(posedge clk) disable iff (rst)
    (burst_end && iter_last && !(cfg_we && cfg_idx == IDX_BITER)) |=> (citer_q == $past(biter_q)));
endmodule

// File: rtl/dce_fsm.sv
module dce_fsm
  import dce_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_en,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             iter_last,
  input  logic             clr_irq,
  input  logic             clr_done,
  output logic             ack,
  output logic             rd_en,
  output logic             wr_en,
  output logic             advance,
  output logic             burst_end,
  output logic             job_end,
  output logic             irq,
  output logic             done
);
  dce_state_t       state_q;
  logic [CNT_W-1:0] left_q;
  logic             ack_q, irq_q, done_q, start;

  assign start     = (state_q == ST_IDLE) && req && req_en;
  assign rd_en     = (state_q == ST_READ);
  assign wr_en     = (state_q == ST_WRITE);
  assign advance   = wr_en;
  assign burst_end = wr_en && (left_q <= CNT_W'(1));
  assign job_end   = burst_end && iter_last;
  assign ack       = ack_q;
  assign irq       = irq_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      ack_q   <= 1'b0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ack_q <= start;
      case (state_q)
        ST_IDLE:  if (start) begin
                    state_q <= ST_READ;
                    left_q  <= nbytes;
                  end
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: begin
                    left_q  <= left_q - CNT_W'(1);
                    state_q <= burst_end ? ST_IDLE : ST_READ;
                  end
        default:  state_q <= ST_IDLE;
      endcase
      if (job_end && irq_en) irq_q <= 1'b1;
      else if (clr_irq)      irq_q <= 1'b0;
      if (job_end)           done_q <= 1'b1;
      else if (clr_done)     done_q <= 1'b0;
    end
  end

  // R8: acknowledge coincides with the first read of a burst
  a_r8_ack_in_read: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (state_q == ST_READ));
  // R1: every read is followed by a write
  a_r1_read_then_write: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ) |=> (state_q == ST_WRITE));
  // R7: with requests disabled the engine stays idle
  a_r7_stay_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !req_en) |=> (state_q == ST_IDLE));
  // R5: interrupt only rises when enabled
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(irq_en));
  // R6: done only rises after a write cycle
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ($past(state_q) == ST_WRITE));
endmodule

// File: rtl/desc_copy_engine.sv
module desc_copy_engine
  import dce_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              dma_req,
  output logic              dma_ack,
  output logic              irq,
  output logic              done,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data
);
  localparam int LANES = 2;

  logic [CNT_W-1:0]  nbytes;
  logic              iter_last, req_en, irq_en, clr_irq, clr_done;
  logic              advance, burst_end, job_end;
  logic [ADDR_W-1:0] lane_addr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dce_addr_lane #(
      .ADDR_W  (ADDR_W),
      .IDX_ADDR(IDX_SRC   + 4'(g)),
      .IDX_STEP(IDX_SSTEP + 4'(g)),
      .IDX_CORR(IDX_SCORR + 4'(g))
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .cfg_we (cfg_we),
      .cfg_idx(cfg_idx),
      .cfg_val(cfg_wdata[ADDR_W-1:0]),
      .advance(advance),
      .job_end(job_end),
      .addr   (lane_addr[g])
    );
  end

  dce_ctl_regs #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .burst_end(burst_end),
    .nbytes   (nbytes),
    .iter_last(iter_last),
    .req_en   (req_en),
    .irq_en   (irq_en),
    .clr_irq  (clr_irq),
    .clr_done (clr_done)
  );

  dce_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (dma_req),
    .req_en   (req_en),
    .irq_en   (irq_en),
    .nbytes   (nbytes),
    .iter_last(iter_last),
    .clr_irq  (clr_irq),
    .clr_done (clr_done),
    .ack      (dma_ack),
    .rd_en    (mem_rd_en),
    .wr_en    (mem_wr_en),
    .advance  (advance),
    .burst_end(burst_end),
    .job_end  (job_end),
    .irq      (irq),
    .done     (done)
  );

  assign mem_rd_addr = lane_addr[0];
  assign mem_wr_addr = lane_addr[1];
  assign mem_wr_data = mem_rd_data;
endmodule

// File: tb/desc_copy_engine_bench.sv
module desc_copy_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic        dma_req = 1'b0;
  logic        dma_ack, irq, done, mem_rd_en, mem_wr_en;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem_rd_data = '0;
  logic [7:0]  mem_wr_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ack_cnt = 0;
  int wr_cnt = 0;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];

  // behavioural model state
  int          m_phase = 0;
  logic [15:0] m_src = '0, m_dst = '0, m_ss = '0, m_ds = '0, m_sc = '0, m_dc = '0;
  int          m_nb = 0, m_cit = 0, m_bit = 0, m_left = 0;
  logic        m_en = 0, m_ien = 0, m_ack = 0, m_irq = 0, m_done = 0;
  logic [7:0]  m_data = '0;

  always #2 clk = ~clk;

  desc_copy_engine u_desc_copy_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .dma_req(dma_req), .dma_ack(dma_ack), .irq(irq), .done(done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];
    if (mem_wr_en) mem[mem_wr_addr[7:0]] <= mem_wr_data;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_src = '0; m_dst = '0; m_ss = '0; m_ds = '0; m_sc = '0; m_dc = '0;
      m_nb = 0; m_cit = 0; m_bit = 0; m_left = 0; m_en = 0; m_ien = 0;
      m_ack = 0; m_irq = 0; m_done = 0; m_data = '0;
    end else begin
      bit fin, job;
      fin = 0; job = 0;
      if (cfg_we) begin
        case (cfg_idx)
          4'd0: m_src = cfg_wdata;
          4'd1: m_dst = cfg_wdata;
          4'd2: m_ss = cfg_wdata;
          4'd3: m_ds = cfg_wdata;
          4'd4: m_nb = cfg_wdata;
          4'd5: m_cit = cfg_wdata;
          4'd6: m_bit = cfg_wdata;
          4'd7: m_sc = cfg_wdata;
          4'd8: m_dc = cfg_wdata;
          4'd9: begin m_en = cfg_wdata[0]; m_ien = cfg_wdata[1]; end
          4'd10: begin
            if (cfg_wdata[0]) m_irq = 0;
            if (cfg_wdata[1]) m_done = 0;
          end
          default: ;
        endcase
      end
      m_ack = 0;
      if (m_phase == 0) begin
        if (dma_req && m_en) begin m_phase = 1; m_ack = 1; m_left = m_nb; end
      end else if (m_phase == 1) begin
        m_data = exp_mem[m_src[7:0]];
        m_phase = 2;
      end else begin
        exp_mem[m_dst[7:0]] = m_data;
        fin = (m_left <= 1);
        m_left = m_left - 1;
        job = fin && (m_cit <= 1);
        m_src = m_src + m_ss + (job ? m_sc : 16'd0);
        m_dst = m_dst + m_ds + (job ? m_dc : 16'd0);
        if (fin) m_cit = (m_cit <= 1) ? m_bit : m_cit - 1;
        m_phase = fin ? 0 : 1;
        if (job) begin m_done = 1; if (m_ien) m_irq = 1; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      if (dma_ack) ack_cnt++;
      if (mem_wr_en) wr_cnt++;
      chk(dma_ack == m_ack, "R8 ack", dma_ack, m_ack);
      chk(mem_rd_en == (m_phase == 1), "R1 rd_en", mem_rd_en, m_phase == 1);
      chk(mem_wr_en == (m_phase == 2), "R1 wr_en", mem_wr_en, m_phase == 2);
      if (m_phase == 1) chk(mem_rd_addr == m_src, "R2/R4 rd_addr", mem_rd_addr, m_src);
      if (m_phase == 2) begin
        chk(mem_wr_addr == m_dst, "R2/R4 wr_addr", mem_wr_addr, m_dst);
        chk(mem_wr_data == m_data, "R1 wr_data", mem_wr_data, m_data);
      end
      chk(irq == m_irq, "R5 irq", irq, m_irq);
      chk(done == m_done, "R6/R3 done", done, m_done);
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int idx, input int val);
    @(posedge clk); #1;
    cfg_we = 1; cfg_idx = 4'(idx); cfg_wdata = 16'(val);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic req_for(input int n);
    @(posedge clk); #1;
    dma_req = 1;
    repeat (n) @(posedge clk);
    #1 dma_req = 0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (m_phase != 0);
    @(posedge clk); #1;
  endtask

  task automatic setup(input int s, input int d, input int ss, input int ds, input int nb,
                       input int cit, input int bit_, input int sc, input int dc, input int ctl);
    wr(0, s); wr(1, d); wr(2, ss); wr(3, ds); wr(4, nb);
    wr(5, cit); wr(6, bit_); wr(7, sc); wr(8, dc); wr(9, ctl);
  endtask

  initial begin
    int a0, w0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!dma_ack && !irq && !done && !mem_rd_en && !mem_wr_en, "R10 reset", {dma_ack, irq, done}, 0);

    // job of 8 bytes, step 1, correction -8, interrupt enabled
    setup(16'h10, 16'h80, 1, 1, 8, 1, 1, 16'hFFF8, 16'hFFF8, 3);
    req_for(1);
    wait_idle();
    chk(irq == 1, "R5 irq set at job end", irq, 1);
    chk(done == 1, "R6 done set at job end", done, 1);
    for (int i = 0; i < 8; i++)
      chk(mem[8'h80 + i] == mem[8'h10 + i], "R1 copied byte", mem[8'h80 + i], mem[8'h10 + i]);
    wr(10, 1);
    chk(irq == 0 && done == 1, "R5 irq cleared alone", {irq, done}, 2'b01);
    wr(10, 2);
    chk(done == 0, "R6 done cleared", done, 0);
    // second job starts from restored addresses (R4 checked by model compare)
    req_for(1);
    wait_idle();
    wr(10, 3);

    // disabled request ignored
    wr(9, 0);
    a0 = ack_cnt; w0 = wr_cnt;
    req_for(3);
    repeat (6) @(posedge clk);
    #1;
    chk(ack_cnt == a0 && wr_cnt == w0, "R7 request ignored", ack_cnt - a0, 0);

    // two-burst jobs, negative destination step, no interrupt
    setup(16'h40, 16'hC0, 2, 16'hFFFF, 3, 2, 2, 0, 5, 1);
    w0 = wr_cnt;
    req_for(1);
    wait_idle();
    chk(done == 0, "R3 first burst not a job end", done, 0);
    chk(wr_cnt - w0 == 3, "R1 burst byte count", wr_cnt - w0, 3);
    req_for(1);
    wait_idle();
    chk(done == 1 && irq == 0, "R5/R3 job end without irq", {irq, done}, 2'b01);
    wr(10, 2);
    req_for(1);
    wait_idle();
    chk(done == 0, "R3 reloaded count first burst", done, 0);
    req_for(1);
    wait_idle();
    chk(done == 1, "R3 reloaded count second burst", done, 1);
    wr(10, 3);

    // zero byte count
    setup(16'h05, 16'h60, 1, 1, 0, 1, 1, 0, 0, 1);
    w0 = wr_cnt;
    req_for(1);
    wait_idle();
    chk(wr_cnt - w0 == 1, "R9 zero count moves one byte", wr_cnt - w0, 1);
    wr(10, 3);

    // held request: one acknowledge per burst
    setup(16'h30, 16'h70, 1, 1, 2, 4, 4, 0, 0, 1);
    a0 = ack_cnt;
    req_for(3);
    wait_idle();
    chk(ack_cnt - a0 == 1, "R8 single ack while busy", ack_cnt - a0, 1);

    for (int i = 0; i < 256; i++)
      chk(mem[i] == exp_mem[i], "R1 final memory", mem[i], exp_mem[i]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule